// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM array alive by issuing CAS-before-RAS refresh cycles. The array has two ranks. An interval timer produces one refresh request every 15.625 µs by default, which spreads 1024 refreshes across each 16 ms window. Requests that the memory access arbiter has not yet served are held in a small counter. The block asks for the bus with `req_o`. When the arbiter answers with `grant_i`, the block runs the strobe sequence on its own.

In each refresh the four CAS lanes fall together first. The RAS lines of both ranks then fall together. CAS is released after its hold time, RAS is released after its minimum low time, and a precharge interval follows. No row address is driven, because the DRAM steps its own internal row counter. The write strobe stays high at all times. Every minimum time is given in picoseconds and turned into a clock count rounded up, so the same block works at any clock period.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all `ras_n_o` and `cas_n_o` bits are 1, `we_n_o` is 1, and `busy_o`, `done_o`, `req_o` and `overflow_o` are 0.
- R2: The interval timer adds one pending request every INTERVAL clock edges, counted from reset release. The interval is ceil(T_INTERVAL_PS / T_CLK_PS). `req_o` is 1 exactly while at least one request is pending, so after reset it first goes high after edge INTERVAL.
- R3: A refresh starts only on an edge where `grant_i` is 1, a request is pending and no refresh is running. A grant with nothing pending has no effect on the strobes or on `busy_o`.
- R4: In each refresh all CAS lanes are low for LEAD = ceil(T_CSR_PS / T_CLK_PS) cycles before the RAS lines of both ranks fall together.
- R5: CAS stays low for CHR = ceil(T_CHR_PS / T_CLK_PS) cycles counted from the first RAS-low cycle, and is high for the rest of the RAS pulse.
- R6: RAS is low for RAS = ceil(T_RAS_PS / T_CLK_PS) cycles. It is then high, with CAS high, for max(ceil(T_RP_PS / T_CLK_PS), ceil(T_RPC_PS / T_CLK_PS)) cycles of precharge before another refresh can start.
- R7: `we_n_o` is 1 in every cycle.
- R8: `busy_o` is 1 from the cycle after the accepting edge through the last precharge cycle. `done_o` is 1 for exactly the one cycle that follows the precharge.
- R9: Each started refresh consumes one pending request. Up to QUEUE_DEPTH (default 4) requests are held. With the grant held high, queued refreshes run one after another, with one idle cycle between them, so that `done_o` pulses are (LEAD + RAS + PRE + 1) cycles apart.
- R10: If a timer request arrives while QUEUE_DEPTH requests are already pending and no refresh starts on that edge, `overflow_o` goes to 1 after that edge and stays at 1 until reset. The pending count does not grow past QUEUE_DEPTH.
- R11: Every minimum time is rounded up to whole clocks. With an 8 ns clock and the defaults, this gives LEAD = 1, CHR = 2, RAS = 8 and PRE = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Arbiter grant for a refresh |
| req_o | output | 1 | Refresh pending, request to arbiter |
| busy_o | output | 1 | Refresh sequence in progress |
| done_o | output | 1 | One-cycle pulse after each completed refresh |
| overflow_o | output | 1 | Sticky flag, a request was lost |
| ras_n_o | output | RANKS | Row strobe per rank, active low |
| cas_n_o | output | LANES | Column strobe per byte lane, active low |
| we_n_o | output | 1 | Write strobe, held high |

## Verification
The strobe state registers change on the accepting edge. The strobes are decoded straight from those registers, so the first CAS-low cycle is visible in the cycle right after the grant edge. Each later phase appears a fixed number of edges after that: RAS falls LEAD edges after the grant edge, `done_o` appears LEAD+RAS+PRE edges after it, and `req_o` rises on the same edge that the timer counts its last cycle. The bench keeps an edge counter that starts at reset release. It drives inputs and samples outputs on falling edges. It walks a per-cycle table of expected strobe levels from the accepting edge onward, and it checks request, overflow and `done_o` spacing at edge numbers computed from the interval and the phase lengths.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_RASLO = 2'd2,
        ST_PRE   = 2'd3
    } seq_state_e;

    // Minimum time in picoseconds to whole clocks, rounded up, at least one.
    function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                              input int unsigned clk_ps);
        int unsigned r;
        r = (t_ps + clk_ps - 1) / clk_ps;
        if (r == 0) r = 1;
        return r;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 1562500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned W = $clog2(INTERVAL_CYC + 1);
    localparam logic [W-1:0] LAST = W'(INTERVAL_CYC - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == LAST) tmr_d.cnt = '0;
        else                   tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick_o = (tmr_q.cnt == LAST);

    // R2: the count wraps to zero on the edge after a tick
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (tmr_q.cnt == '0));

endmodule

// File: rtl/cbr_pending_queue.sv
module cbr_pending_queue #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic take_i,
    output logic pending_o,
    output logic overflow_o
);
    localparam int unsigned QW = $clog2(DEPTH + 1);
    localparam logic [QW-1:0] QMAX = QW'(DEPTH);

    typedef struct packed {
        logic [QW-1:0] cnt;
        logic          ovf;
    } pq_t;

    pq_t pq_d, pq_q;

    always_comb begin
        pq_d = pq_q;
        if (tick_i && !take_i) begin
            if (pq_q.cnt == QMAX) pq_d.ovf = 1'b1;
            else                  pq_d.cnt = pq_q.cnt + 1'b1;
        end else if (take_i && !tick_i) begin
            pq_d.cnt = pq_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pq_q <= '0;
        else        pq_q <= pq_d;
    end

    assign pending_o  = (pq_q.cnt != '0);
    assign overflow_o = pq_q.ovf;

    // R9: the pending count never exceeds the queue depth
    a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pq_q.cnt <= QMAX);

    // R9: a refresh is only started while something is pending
    a_r9_take_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pending_o);

    // R10: the loss flag is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
    import cbr_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 1,
    parameter int unsigned CHR_CYC  = 1,
    parameter int unsigned RAS_CYC  = 6,
    parameter int unsigned PRE_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic idle_o,
    output logic ras_act_o,
    output logic cas_act_o,
    output logic done_o
);
    localparam int unsigned MAXC  = max2(max2(LEAD_CYC, RAS_CYC), PRE_CYC);
    localparam int unsigned CW    = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_CYC - 1);
    localparam logic [CW-1:0] RAS_LAST  = CW'(RAS_CYC - 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] CHR_END   = CW'(CHR_CYC);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.cnt  = seq_q.cnt + 1'b1;
        unique case (seq_q.st)
            ST_IDLE: begin
                seq_d.cnt = '0;
                if (start_i) seq_d.st = ST_LEAD;
            end
            ST_LEAD: begin
                if (seq_q.cnt == LEAD_LAST) begin
                    seq_d.st  = ST_RASLO;
                    seq_d.cnt = '0;
                end
            end
            ST_RASLO: begin
                if (seq_q.cnt == RAS_LAST) begin
                    seq_d.st  = ST_PRE;
                    seq_d.cnt = '0;
                end
            end
            ST_PRE: begin
                if (seq_q.cnt == PRE_LAST) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.cnt  = '0;
                    seq_d.done = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.cnt  <= '0;
            seq_q.done <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idle_o    = (seq_q.st == ST_IDLE);
    assign ras_act_o = (seq_q.st == ST_RASLO);
    assign cas_act_o = (seq_q.st == ST_LEAD) ||
                       ((seq_q.st == ST_RASLO) && (seq_q.cnt < CHR_END));
    assign done_o    = seq_q.done;

    // Run length of the current RAS pulse, for the width check
    localparam int unsigned RW = $clog2(RAS_CYC + 2);
    logic [RW-1:0] ras_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ras_run_q <= '0;
        else if (ras_act_o) ras_run_q <= ras_run_q + 1'b1;
        else                ras_run_q <= '0;
    end

    // R4: CAS is already low in the cycle before RAS falls
    a_r4_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_act_o) |-> $past(cas_act_o));

    // R6: a RAS pulse ends only after its full width
    a_r6_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_act_o) |-> (ras_run_q == RW'(RAS_CYC)));

    // R8: completion is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
    import cbr_pkg::*;
#(
    parameter int unsigned T_CLK_PS      = 10000,
    parameter int unsigned T_INTERVAL_PS = 15625000,
    parameter int unsigned T_CSR_PS      = 5000,
    parameter int unsigned T_CHR_PS      = 10000,
    parameter int unsigned T_RAS_PS      = 60000,
    parameter int unsigned T_RP_PS       = 40000,
    parameter int unsigned T_RPC_PS      = 5000,
    parameter int unsigned RANKS         = 2,
    parameter int unsigned LANES         = 4,
    parameter int unsigned QUEUE_DEPTH   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_i,
    output logic             req_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             overflow_o,
    output logic [RANKS-1:0] ras_n_o,
    output logic [LANES-1:0] cas_n_o,
    output logic             we_n_o
);
    localparam int unsigned INTERVAL_CYC = ps_to_cyc(T_INTERVAL_PS, T_CLK_PS);
    localparam int unsigned LEAD_CYC     = ps_to_cyc(T_CSR_PS, T_CLK_PS);
    localparam int unsigned CHR_CYC      = ps_to_cyc(T_CHR_PS, T_CLK_PS);
    localparam int unsigned RAS_CYC      = max2(ps_to_cyc(T_RAS_PS, T_CLK_PS), CHR_CYC);
    localparam int unsigned PRE_CYC      = max2(ps_to_cyc(T_RP_PS, T_CLK_PS),
                                                ps_to_cyc(T_RPC_PS, T_CLK_PS));

    logic tick, pending, idle, start, ras_act, cas_act;

    assign start = grant_i && pending && idle;

    cbr_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    cbr_pending_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .take_i     (start),
        .pending_o  (pending),
        .overflow_o (overflow_o)
    );

    cbr_strobe_seq #(
        .LEAD_CYC (LEAD_CYC),
        .CHR_CYC  (CHR_CYC),
        .RAS_CYC  (RAS_CYC),
        .PRE_CYC  (PRE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .idle_o    (idle),
        .ras_act_o (ras_act),
        .cas_act_o (cas_act),
        .done_o    (done_o)
    );

    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        assign ras_n_o[r] = ~ras_act;
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign cas_n_o[l] = ~cas_act;
    end

    assign req_o  = pending;
    assign busy_o = ~idle;
    assign we_n_o = 1'b1;

    // R8: an accepted grant makes the block busy on the next cycle
    a_r8_busy_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && req_o && !busy_o) |=> busy_o);

    // R3: the strobes stay quiet while idle
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (&ras_n_o) && (&cas_n_o));

endmodule

// File: tb/sim_cbr_refresh_sched.sv
`timescale 1ns/1ps
module sim_cbr_refresh_sched;
    localparam int RANKS = 2;
    localparam int LANES = 4;
    // 8 ns clock, 1.6 us interval -> 200 cycles; LEAD 1, CHR 2, RAS 8, PRE 5
    localparam int INTERVAL = 200;
    localparam int SPACING  = 1 + 8 + 5 + 1;

    // Expected {busy, ras_n, cas_n, done} per cycle after the accepting edge
    localparam logic [3:0] VEC [16] = '{
        4'b1100, 4'b1000, 4'b1000, 4'b1010, 4'b1010, 4'b1010, 4'b1010, 4'b1010,
        4'b1010, 4'b1110, 4'b1110, 4'b1110, 4'b1110, 4'b1110, 4'b0111, 4'b0110
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0;
    logic req, busy, done, ovf, we_n;
    logic [RANKS-1:0] ras_n;
    logic [LANES-1:0] cas_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    cbr_refresh_sched #(
        .T_CLK_PS      (8000),
        .T_INTERVAL_PS (1600000),
        .RANKS         (RANKS),
        .LANES         (LANES)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_i    (grant),
        .req_o      (req),
        .busy_o     (busy),
        .done_o     (done),
        .overflow_o (ovf),
        .ras_n_o    (ras_n),
        .cas_n_o    (cas_n),
        .we_n_o     (we_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        int dones;
        int first_done;
        int last_done;
        int gap_bad;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ras_n", ras_n, 2'b11);
        chk("R1 cas_n", cas_n, 4'hf);
        chk("R1 we_n", we_n, 1'b1);
        chk("R1 busy/done/req/ovf", {busy, done, req, ovf}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle", {busy, done, req, ovf, ras_n, cas_n}, {4'b0000, 2'b11, 4'hf});

        // R3: grant with nothing pending is ignored
        grant = 1'b1;
        wait_cyc(6);
        chk("R3 busy", busy, 1'b0);
        chk("R3 strobes", {ras_n, cas_n}, {2'b11, 4'hf});
        grant = 1'b0;

        // R2: first request after INTERVAL edges
        wait_cyc(INTERVAL - 1);
        chk("R2 req early", req, 1'b0);
        wait_cyc(INTERVAL);
        chk("R2 req due", req, 1'b1);

        // Table walk: one refresh, R4 R5 R6 R7 R8 R11
        grant = 1'b1;
        for (int k = 0; k < 16; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 0) begin
                grant = 1'b0;
                chk("R9 request consumed", req, 1'b0);
            end
            chk($sformatf("R4 R5 R6 R11 strobes k=%0d", k),
                {ras_n, cas_n}, {{RANKS{VEC[k][2]}}, {LANES{VEC[k][1]}}});
            chk($sformatf("R8 busy/done k=%0d", k), {busy, done}, {VEC[k][3], VEC[k][0]});
            chk("R7 we_n", we_n, 1'b1);
        end

        // R9/R10: fill the queue to its depth, then overflow
        wait_cyc(5 * INTERVAL + 5);
        chk("R10 no overflow at depth", ovf, 1'b0);
        chk("R9 req with queue full", req, 1'b1);
        wait_cyc(6 * INTERVAL + 5);
        chk("R10 overflow set", ovf, 1'b1);

        // R9: drain back-to-back with grant held
        grant = 1'b1;
        dones = 0;
        first_done = 0;
        last_done = 0;
        gap_bad = 0;
        while (cyc < 6 * INTERVAL + 100) begin
            @(negedge clk);
            chk("R7 we_n drain", we_n, 1'b1);
            if (done) begin
                if (dones == 0) first_done = cyc;
                else if (cyc - last_done != SPACING) gap_bad++;
                last_done = cyc;
                dones++;
            end
        end
        grant = 1'b0;
        chk("R9 refresh count", dones, 4);
        chk("R8 first done edge", first_done, 6 * INTERVAL + 6 + 14);
        chk("R9 done spacing", gap_bad, 0);
        chk("R9 queue empty", req, 1'b0);
        chk("R10 overflow sticky", ovf, 1'b1);
        chk("R3 idle after drain", {busy, ras_n, cas_n}, {1'b0, 2'b11, 4'hf});

        finished = 1'b1;
        summary();
    end

endmodule